// File: doc/BRIEF.md
# Multi-Address I2C Slave Responder

This block is the target side of a two-wire serial bus. It watches the clock and data lines and catches each start condition. It then compares the address byte that follows with a small set of own-address slots. Each slot has its own don't-care mask. The block can also accept the all-zero general call address. When an address hits and acknowledging is enabled, the block takes part in the transfer. It receives bytes from the bus master, or it sends bytes supplied by the local controller.

Every bus event the controller has to act on raises an event flag and loads an 8-bit status code. Most of these events also stretch the clock, holding SCL low until the controller pulses the flag-clear input. Before that pulse, the controller sets the acknowledge-enable input and the next byte to send, and these settings steer the next step of the transfer. A stop or a repeated start seen while the block is addressed is reported with a code of its own, and that event does not stretch the clock.

The bus lines are open drain. The block only ever asks to pull a line low, through `scl_low_o` and `sda_low_o`. The pad logic outside the block does the wired-AND.

Top module: `i2cs_multi_slave`

## Requirements
- R1: After reset, `irq_flag_o` is 0, `status_o` is 0xF8, and neither bus line is pulled low.
- R2: Slot i holds an address in bits 7:1 of `own_addr_i[8*i+7:8*i]`, with a mask in the same bits of `addr_mask_i`. The read/write bit (bit 0 of the received byte) is left out of the compare, and a mask bit of 1 makes that address bit a don't-care. A received byte whose bits 7:1 match no slot is not acknowledged.
- R3: The byte 0x00 is a general call. It is accepted only when bit 0 of slot 0's address is 1, and then it gives status 0x70. An address of all zeros never counts as an own-address match.
- R4: While `ack_en_i` is 0, no address is acknowledged and no event is raised.
- R5: An own address with bit 0 = 0 (write) gives status 0x60. With bit 0 = 1 (read), it gives status 0xA8.
- R6: In a write transfer, each data byte appears on `rx_byte_o`. If it was acknowledged, the status is 0x80 after an own-address write, or 0x90 after a general call. If `ack_en_i` was 0 at the acknowledge slot, the byte is not acknowledged and the status is 0x88 or 0x98.
- R7: In a read transfer, `tx_byte_i` is captured when the flag is cleared and is sent MSB first. A byte the master acknowledges gives 0xB8. A byte the master does not acknowledge gives 0xC0. A byte that was loaded while `ack_en_i` was 0, and that the master still acknowledges, gives 0xC8.
- R8: A stop or repeated start while addressed gives status 0xA0 without holding SCL. After a repeated start, a new address phase follows.
- R9: From the cycle an event other than 0xA0 is posted until the cycle after `flag_clr_i`, SCL is held low and SDA is released. The flag falls only on a clear.
- R10: After status 0xA0, 0x88, 0x98, 0xC0 or 0xC8, the block stops listening until the next start: bytes in between are neither acknowledged nor reported.
- R11: `status_o` changes only together with a raised event flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Sensed level of the clock line |
| sda_i | input | 1 | Sensed level of the data line |
| scl_low_o | output | 1 | 1 pulls the clock line low (stretch) |
| sda_low_o | output | 1 | 1 pulls the data line low |
| own_addr_i | input | 8*SLOTS | Own address per slot in bits 7:1; bit 0 of slot 0 enables the general call |
| addr_mask_i | input | 8*SLOTS | Don't-care mask per slot in bits 7:1 |
| ack_en_i | input | 1 | Acknowledge enable |
| flag_clr_i | input | 1 | One-cycle pulse that clears the event flag and releases SCL |
| tx_byte_i | input | 8 | Next byte to transmit, captured on clear |
| irq_flag_o | output | 1 | Event flag |
| status_o | output | 8 | Code of the most recent event |
| rx_byte_o | output | 8 | Most recently received byte |

## Verification
The assertions assume that `flag_clr_i` is pulsed only while the flag is high. They also assume that the master changes SDA only while SCL is low, except when it makes a start or a stop, and that every SCL phase lasts longer than the synchronizer latency. The bench master drives the bus in quarter-bit steps of ten clock cycles, which is well beyond that latency. It waits for SCL to read high before it treats a bit as started, so clock stretching is respected. The controller model in the bench clears the flag only after it has seen the flag raised.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

   localparam int BYTE_W = 8;
   localparam int CNT_W  = 4;

   localparam logic [7:0] ST_IDLE     = 8'hF8;
   localparam logic [7:0] ST_OWN_WR   = 8'h60;
   localparam logic [7:0] ST_GC       = 8'h70;
   localparam logic [7:0] ST_RX_ACK   = 8'h80;
   localparam logic [7:0] ST_RX_NACK  = 8'h88;
   localparam logic [7:0] ST_GC_ACK   = 8'h90;
   localparam logic [7:0] ST_GC_NACK  = 8'h98;
   localparam logic [7:0] ST_BUS_END  = 8'hA0;
   localparam logic [7:0] ST_OWN_RD   = 8'hA8;
   localparam logic [7:0] ST_TX_ACK   = 8'hB8;
   localparam logic [7:0] ST_TX_NACK  = 8'hC0;
   localparam logic [7:0] ST_TX_LAST  = 8'hC8;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ADDR,
      S_AACK,
      S_RX,
      S_RACK,
      S_TX,
      S_TACK,
      S_HOLD
   } eng_state_t;

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   localparam int DEPTH = STAGES + 1;

   logic [DEPTH-1:0] scl_pipe;
   logic [DEPTH-1:0] sda_pipe;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2cs_line_sync: STAGES must be at least 2");
      end
      if (DEPTH == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe[0] <= scl_i;
               sda_pipe[0] <= sda_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= {scl_pipe[DEPTH-2:0], scl_i};
               sda_pipe <= {sda_pipe[DEPTH-2:0], sda_i};
            end
         end
      end
   endgenerate

   logic scl_now, scl_prev, sda_now, sda_prev;

   assign scl_now  = scl_pipe[DEPTH-2];
   assign scl_prev = scl_pipe[DEPTH-1];
   assign sda_now  = sda_pipe[DEPTH-2];
   assign sda_prev = sda_pipe[DEPTH-1];

   assign sda_lvl   = sda_now;
   assign scl_rise  = scl_now & ~scl_prev;
   assign scl_fall  = ~scl_now & scl_prev;
   assign start_det = scl_now & scl_prev & sda_prev & ~sda_now;
   assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;

endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match #(
   parameter int SLOTS  = 4,
   parameter bit MASKED = 1'b1
) (
   input  logic [7:0]         rx_addr,
   input  logic [8*SLOTS-1:0] own_addr,
   input  logic [8*SLOTS-1:0] addr_mask,
   output logic               hit_own,
   output logic               hit_gc
);

   logic [SLOTS-1:0] slot_hit;

   genvar gi;
   generate
      for (gi = 0; gi < SLOTS; gi++) begin : g_slot
         logic [6:0] slot_addr;
         logic [6:0] slot_mask;
         assign slot_addr = own_addr[8*gi+7 : 8*gi+1];
         assign slot_mask = addr_mask[8*gi+7 : 8*gi+1];
         if (MASKED) begin : g_masked
            assign slot_hit[gi] = ((rx_addr[7:1] ^ slot_addr) & ~slot_mask) == 7'd0;
         end else begin : g_exact
            logic unused_mask;
            assign unused_mask  = ^slot_mask;
            assign slot_hit[gi] = (rx_addr[7:1] == slot_addr);
         end
      end
   endgenerate

   logic zero_addr;
   assign zero_addr = (rx_addr[7:1] == 7'd0);

   assign hit_gc  = (rx_addr == 8'h00) & own_addr[0];
   assign hit_own = (|slot_hit) & ~zero_addr;

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
   import i2cs_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sda_lvl,
   input  logic        scl_rise,
   input  logic        scl_fall,
   input  logic        start_det,
   input  logic        stop_det,
   input  logic        hit_own,
   input  logic        hit_gc,
   input  logic        ack_en,
   input  logic        flag_clr,
   input  logic [7:0]  tx_byte,
   output logic [7:0]  shreg,
   output logic        scl_low,
   output logic        sda_low,
   output logic        flag,
   output logic [7:0]  status,
   output logic [7:0]  rx_byte
);

   localparam logic [CNT_W-1:0] LAST_RX  = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

   eng_state_t       state, resume;
   logic [CNT_W-1:0] cnt;
   logic             gc_path, rd_path, last_tx, acked, master_ack;
   logic             addressed;

   assign addressed = (state == S_AACK) || (state == S_RX) || (state == S_RACK) ||
                      (state == S_TX)   || (state == S_TACK) || (state == S_HOLD);
   assign scl_low   = (state == S_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         resume     <= S_IDLE;
         cnt        <= '0;
         shreg      <= '0;
         sda_low    <= 1'b0;
         flag       <= 1'b0;
         status     <= ST_IDLE;
         rx_byte    <= '0;
         gc_path    <= 1'b0;
         rd_path    <= 1'b0;
         last_tx    <= 1'b0;
         acked      <= 1'b0;
         master_ack <= 1'b0;
      end else begin
         if (flag_clr) flag <= 1'b0;

         if (stop_det) begin
            if (addressed) begin
               flag   <= 1'b1;
               status <= ST_BUS_END;
            end
            state   <= S_IDLE;
            sda_low <= 1'b0;
         end else if (start_det) begin
            if (addressed) begin
               flag   <= 1'b1;
               status <= ST_BUS_END;
            end
            state   <= S_ADDR;
            cnt     <= '0;
            sda_low <= 1'b0;
         end else begin
            unique case (state)
               S_IDLE: ;

               S_ADDR: begin
                  if (scl_rise) begin
                     shreg <= {shreg[6:0], sda_lvl};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == LAST_RX) begin
                     rx_byte <= shreg;
                     if ((hit_own || hit_gc) && ack_en) begin
                        sda_low <= 1'b1;
                        gc_path <= hit_gc;
                        rd_path <= shreg[0] & ~hit_gc;
                        state   <= S_AACK;
                     end else begin
                        state <= S_IDLE;
                     end
                  end
               end

               S_AACK: begin
                  if (scl_fall) begin
                     sda_low <= 1'b0;
                     flag    <= 1'b1;
                     status  <= gc_path ? ST_GC : (rd_path ? ST_OWN_RD : ST_OWN_WR);
                     resume  <= rd_path ? S_TX : S_RX;
                     state   <= S_HOLD;
                  end
               end

               S_RX: begin
                  if (scl_rise) begin
                     shreg <= {shreg[6:0], sda_lvl};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == LAST_RX) begin
                     rx_byte <= shreg;
                     acked   <= ack_en;
                     sda_low <= ack_en;
                     state   <= S_RACK;
                  end
               end

               S_RACK: begin
                  if (scl_fall) begin
                     sda_low <= 1'b0;
                     flag    <= 1'b1;
                     if (acked) status <= gc_path ? ST_GC_ACK : ST_RX_ACK;
                     else       status <= gc_path ? ST_GC_NACK : ST_RX_NACK;
                     resume  <= acked ? S_RX : S_IDLE;
                     state   <= S_HOLD;
                  end
               end

               S_TX: begin
                  if (scl_fall) begin
                     if (cnt == LAST_TX) begin
                        sda_low <= 1'b0;
                        state   <= S_TACK;
                     end else begin
                        sda_low <= ~shreg[6];
                        shreg   <= {shreg[6:0], 1'b0};
                        cnt     <= cnt + 1'b1;
                     end
                  end
               end

               S_TACK: begin
                  if (scl_rise) begin
                     master_ack <= ~sda_lvl;
                  end else if (scl_fall) begin
                     flag <= 1'b1;
                     if (!master_ack)  status <= ST_TX_NACK;
                     else if (last_tx) status <= ST_TX_LAST;
                     else              status <= ST_TX_ACK;
                     resume <= (master_ack && !last_tx) ? S_TX : S_IDLE;
                     state  <= S_HOLD;
                  end
               end

               S_HOLD: begin
                  if (flag_clr) begin
                     state <= resume;
                     cnt   <= '0;
                     if (resume == S_TX) begin
                        shreg   <= tx_byte;
                        sda_low <= ~tx_byte[7];
                        last_tx <= ~ack_en;
                     end
                  end
               end

               default: state <= S_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/i2cs_multi_slave.sv
module i2cs_multi_slave
   import i2cs_pkg::*;
#(
   parameter int SLOTS       = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit MASKED      = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               scl_low_o,
   output logic               sda_low_o,
   input  logic [8*SLOTS-1:0] own_addr_i,
   input  logic [8*SLOTS-1:0] addr_mask_i,
   input  logic               ack_en_i,
   input  logic               flag_clr_i,
   input  logic [7:0]         tx_byte_i,
   output logic               irq_flag_o,
   output logic [7:0]         status_o,
   output logic [7:0]         rx_byte_o
);

   generate
      if (SLOTS < 1 || SLOTS > 8) begin : g_bad_slots
         $error("i2cs_multi_slave: SLOTS must be 1 to 8");
      end
   endgenerate

   logic       sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic       hit_own, hit_gc;
   logic [7:0] shreg;

   i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2cs_addr_match #(.SLOTS(SLOTS), .MASKED(MASKED)) u_match (
      .rx_addr   (shreg),
      .own_addr  (own_addr_i),
      .addr_mask (addr_mask_i),
      .hit_own   (hit_own),
      .hit_gc    (hit_gc)
   );

   i2cs_engine u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .hit_own   (hit_own),
      .hit_gc    (hit_gc),
      .ack_en    (ack_en_i),
      .flag_clr  (flag_clr_i),
      .tx_byte   (tx_byte_i),
      .shreg     (shreg),
      .scl_low   (scl_low_o),
      .sda_low   (sda_low_o),
      .flag      (irq_flag_o),
      .status    (status_o),
      .rx_byte   (rx_byte_o)
   );

endmodule

// File: rtl/i2cs_multi_slave_chk.sv
module i2cs_multi_slave_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_low_o,
   input logic       sda_low_o,
   input logic       irq_flag_o,
   input logic [7:0] status_o,
   input logic       flag_clr_i
);

   p_stretch_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      scl_low_o |-> irq_flag_o);

   p_stretch_frees_sda_r9: assert property (@(posedge clk) disable iff (!rst_n)
      scl_low_o |-> !sda_low_o);

   p_flag_falls_on_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_flag_o) |-> $past(flag_clr_i));

   p_status_moves_with_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(status_o) |-> irq_flag_o);

   p_bus_end_no_stretch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag_o && status_o == 8'hA0) |-> !scl_low_o);

   p_legal_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag_o) |-> (status_o == 8'h60 || status_o == 8'h70 || status_o == 8'h80 ||
                             status_o == 8'h88 || status_o == 8'h90 || status_o == 8'h98 ||
                             status_o == 8'hA0 || status_o == 8'hA8 || status_o == 8'hB8 ||
                             status_o == 8'hC0 || status_o == 8'hC8));

endmodule

bind i2cs_multi_slave i2cs_multi_slave_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_low_o  (scl_low_o),
   .sda_low_o  (sda_low_o),
   .irq_flag_o (irq_flag_o),
   .status_o   (status_o),
   .flag_clr_i (flag_clr_i)
);

// File: tb/sim_i2cs_multi_slave.sv
`timescale 1ns/1ps
module sim_i2cs_multi_slave;

   localparam int Q = 10;

   typedef struct {
      logic [7:0] st;
      bit         chk_d;
      logic [7:0] d;
      bit         ack_next;
      logic [7:0] tx_next;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        m_scl_low = 1'b0, m_sda_low = 1'b0;
   logic        scl_low_o, sda_low_o, irq_flag_o;
   logic [31:0] own_addr_i, addr_mask_i;
   logic        ack_en_i = 1'b1, flag_clr_i = 1'b0;
   logic [7:0]  tx_byte_i = 8'h00, status_o, rx_byte_o;
   wire         scl_line = ~(m_scl_low | scl_low_o);
   wire         sda_line = ~(m_sda_low | sda_low_o);

   int total = 0, bad = 0;
   bit done = 1'b0;
   item_t exp_q[$];

   i2cs_multi_slave u0 (
      .clk (clk), .rst_n (rst_n), .scl_i (scl_line), .sda_i (sda_line),
      .scl_low_o (scl_low_o), .sda_low_o (sda_low_o),
      .own_addr_i (own_addr_i), .addr_mask_i (addr_mask_i),
      .ack_en_i (ack_en_i), .flag_clr_i (flag_clr_i), .tx_byte_i (tx_byte_i),
      .irq_flag_o (irq_flag_o), .status_o (status_o), .rx_byte_o (rx_byte_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic expect_evt(input logic [7:0] st, input bit chk_d, input logic [7:0] d,
                             input bit ack_next, input logic [7:0] tx_next);
      item_t it;
      it.st = st; it.chk_d = chk_d; it.d = d; it.ack_next = ack_next; it.tx_next = tx_next;
      exp_q.push_back(it);
   endtask

   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic scl_up();
      m_scl_low = 1'b0;
      while (!scl_line) @(negedge clk);
   endtask

   task automatic m_start();
      m_sda_low = 1'b0; wait_q();
      scl_up(); wait_q();
      m_sda_low = 1'b1; wait_q();
      m_scl_low = 1'b1; wait_q();
   endtask

   task automatic m_stop();
      m_sda_low = 1'b1; wait_q();
      scl_up(); wait_q();
      m_sda_low = 1'b0; wait_q();
   endtask

   task automatic wr_bit(input bit b);
      m_sda_low = ~b; wait_q();
      scl_up(); wait_q();
      m_scl_low = 1'b1; wait_q();
   endtask

   task automatic rd_bit(output bit b);
      m_sda_low = 1'b0; wait_q();
      scl_up(); wait_q();
      b = sda_line;
      m_scl_low = 1'b1; wait_q();
   endtask

   task automatic wr_byte(input logic [7:0] v, output bit acked);
      bit b;
      for (int i = 7; i >= 0; i--) wr_bit(v[i]);
      rd_bit(b);
      acked = ~b;
   endtask

   task automatic rd_byte(input bit give_ack, output logic [7:0] v);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         rd_bit(b);
         v[i] = b;
      end
      wr_bit(~give_ack);
   endtask

   task automatic settle(input string tag);
      repeat (30) @(negedge clk);
      chk(exp_q.size() == 0, tag, exp_q.size(), 0);
   endtask

   // monitor: models the local controller and scores every posted event
   initial begin
      item_t it;
      forever begin
         @(negedge clk);
         if (rst_n && irq_flag_o) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R10 unexpected event", status_o, 0);
            end else begin
               it = exp_q.pop_front();
               chk(status_o == it.st, "R5/R6/R7/R8 status", status_o, it.st);
               if (it.chk_d) chk(rx_byte_o == it.d, "R6 rx byte", rx_byte_o, it.d);
               if (it.st == 8'hA0) chk(scl_low_o == 1'b0, "R8 no stretch", scl_low_o, 0);
               else                chk(scl_low_o == 1'b1, "R9 stretch", scl_low_o, 1);
               ack_en_i  = it.ack_next;
               tx_byte_i = it.tx_next;
            end
            flag_clr_i = 1'b1;
            @(negedge clk);
            flag_clr_i = 1'b0;
            chk(irq_flag_o == 1'b0 && scl_low_o == 1'b0, "R9 release", irq_flag_o, 0);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit a;
      logic [7:0] v;
      own_addr_i  = {8'h1E, 8'h60, 8'h44, 8'hA1};
      addr_mask_i = {8'h00, 8'h0E, 8'h00, 8'h00};
      repeat (5) @(negedge clk);
      chk(irq_flag_o == 1'b0, "R1 flag", irq_flag_o, 0);
      chk(status_o == 8'hF8, "R1 status", status_o, 8'hF8);
      chk(scl_low_o == 1'b0 && sda_low_o == 1'b0, "R1 lines", {scl_low_o, sda_low_o}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R2 R5 R6: write to slot 0
      m_start();
      expect_evt(8'h60, 0, 0, 1, 0);
      wr_byte(8'hA0, a); chk(a, "R2 slot0 ack", a, 1);
      expect_evt(8'h80, 1, 8'h3C, 1, 0);
      wr_byte(8'h3C, a); chk(a, "R6 data ack", a, 1);
      expect_evt(8'h80, 1, 8'hC5, 1, 0);
      wr_byte(8'hC5, a); chk(a, "R6 data ack", a, 1);
      expect_evt(8'hA0, 0, 0, 1, 0);
      m_stop();
      settle("R8 stop event");

      // R5 R7: read from slot 1, last byte with ack enable clear
      m_start();
      expect_evt(8'hA8, 0, 0, 1, 8'h96);
      wr_byte(8'h45, a); chk(a, "R5 read ack", a, 1);
      expect_evt(8'hB8, 0, 0, 0, 8'h5A);
      rd_byte(1, v); chk(v == 8'h96, "R7 tx byte", v, 8'h96);
      expect_evt(8'hC8, 0, 0, 1, 0);
      rd_byte(1, v); chk(v == 8'h5A, "R7 last byte", v, 8'h5A);
      m_stop();
      settle("R10 after last byte");

      // R7: master NACK
      m_start();
      expect_evt(8'hA8, 0, 0, 1, 8'hE1);
      wr_byte(8'h45, a); chk(a, "R7 addr ack", a, 1);
      expect_evt(8'hC0, 0, 0, 1, 0);
      rd_byte(0, v); chk(v == 8'hE1, "R7 nack byte", v, 8'hE1);
      m_stop();
      settle("R7 nack event");

      // R2 masked slot 2, R8 repeated start, nonmatching address
      m_start();
      expect_evt(8'h60, 0, 0, 1, 0);
      wr_byte(8'h6A, a); chk(a, "R2 masked ack", a, 1);
      expect_evt(8'h80, 1, 8'h11, 1, 0);
      wr_byte(8'h11, a); chk(a, "R6 data ack", a, 1);
      expect_evt(8'hA0, 0, 0, 1, 0);
      m_start();
      wr_byte(8'hFE, a); chk(!a, "R2 no match nack", a, 0);
      m_stop();
      settle("R8 repeated start");

      // R2: unmasked slot rejects a neighbour address
      m_start();
      wr_byte(8'h46, a); chk(!a, "R2 exact compare", a, 0);
      m_stop();
      settle("R2 no event");

      // R3: general call enabled
      m_start();
      expect_evt(8'h70, 0, 0, 1, 0);
      wr_byte(8'h00, a); chk(a, "R3 gc ack", a, 1);
      expect_evt(8'h90, 1, 8'h77, 1, 0);
      wr_byte(8'h77, a); chk(a, "R6 gc data ack", a, 1);
      expect_evt(8'hA0, 0, 0, 1, 0);
      m_stop();
      settle("R3 gc events");

      // R3: general call disabled
      own_addr_i[7:0] = 8'hA0;
      m_start();
      wr_byte(8'h00, a); chk(!a, "R3 gc disabled", a, 0);
      m_stop();
      settle("R3 no event");
      own_addr_i[7:0] = 8'hA1;

      // R4: acknowledge disabled
      ack_en_i = 1'b0;
      m_start();
      wr_byte(8'hA0, a); chk(!a, "R4 address nack", a, 0);
      chk(irq_flag_o == 1'b0, "R4 no flag", irq_flag_o, 0);
      m_stop();
      settle("R4 no event");
      ack_en_i = 1'b1;

      // R6 R10: slot 3, data byte refused, later byte ignored
      m_start();
      expect_evt(8'h60, 0, 0, 0, 0);
      wr_byte(8'h1E, a); chk(a, "R2 slot3 ack", a, 1);
      expect_evt(8'h88, 1, 8'h42, 1, 0);
      wr_byte(8'h42, a); chk(!a, "R6 data nack", a, 0);
      wr_byte(8'h99, a); chk(!a, "R10 ignored byte", a, 0);
      m_stop();
      settle("R10 no event");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule